// File: doc/BRIEF.md
# Authentication Tag / IV Readback Register

This block is the host-facing readback path for the 128-bit authentication result of a block-cipher engine. One 128-bit storage element holds the engine's authentication state. While the engine runs, that storage carries the running intermediate value. When processing ends, it holds the final tag. The host sees the tag as four read-only 32-bit words. It sees the engine's current IV as four more words.

A read of a tag word can return one of three things. While the engine is busy it returns zero. When a final tag is held, a context-ready status is set and the operation produces a tag, it returns that tag word. In every other case it returns the matching IV word. This covers operations that produce no tag, a tag that has been discarded by a context write, and a tag that has been dropped because the host read the IV first. Hosts that need both values must read the tag words before the IV words.

The read port has one request qualifier (`rd_en_i`) and one result qualifier (`rd_valid_o`). The block accepts every request, so it has no ready signal and applies no back-pressure. The result appears exactly one cycle after the request. The host must take it in the cycle `rd_valid_o` is high, because the block does not hold it any longer. Control and status pins are plain levels or one-cycle strobes.

Top module: `tagiv_readback`

## Requirements
- R1: When a tag is visible, a read at byte address 0x570 + 4k (k = 0..3) returns tag bits [32k+31:32k]. Word k=0 carries the least significant bits.
- R2: While `busy_i` is high, every tag-word read returns 32'h0.
- R3: While `tag_mode_i` is low, a tag-word read returns IV bits [32k+31:32k], even if a tag is held.
- R4: A `tag_valid_i` pulse captures `tag_i` only when `busy_i` is low and `tag_mode_i` is high. A capture sets `ctx_ready_o` from the next cycle. A pulse with `tag_mode_i` low has no effect.
- R5: A `ctx_wr_i` strobe discards the held tag and clears `ctx_ready_o` from the next cycle. Tag-word reads then return IV words.
- R6: A read at byte address 0x540 + 4k returns IV bits [32k+31:32k]. Such a read made while a tag is held drops the tag, so later tag-word reads return IV data. `ctx_ready_o` stays set.
- R7: `rd_valid_o` is high exactly in the cycle after a cycle with `rd_en_i` high. `rd_data_o` is 32'h0 whenever `rd_valid_o` is low.
- R8: A read at any other address returns 32'h0. This includes byte addresses with bits [1:0] not zero.
- R9: A synchronous active-high `rst` clears the tag storage, the held flag, `ctx_ready_o`, `rd_valid_o` and `rd_data_o`.
- R10: If `ctx_wr_i` and a capture fall in the same cycle, the context write wins. No tag is held afterward and `ctx_ready_o` is low.
- R11: If a capture and an IV-word read fall in the same cycle, the read returns IV data and the capture wins. The new tag is held afterward.
- R12: A `tag_valid_i` pulse while `busy_i` is high loads intermediate state into the shared storage and drops any held tag. After `busy_i` falls, tag-word reads return IV data until the next capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Engine processing |
| tag_mode_i | input | 1 | Current operation produces a tag |
| tag_valid_i | input | 1 | Strobe: `tag_i` carries new authentication state |
| tag_i | input | 128 | Authentication state / final tag |
| iv_i | input | 128 | Current IV register contents |
| ctx_wr_i | input | 1 | Strobe: a new context is being written |
| rd_en_i | input | 1 | Host read request |
| rd_addr_i | input | 12 | Host byte address |
| rd_data_o | output | 32 | Read result, one cycle after the request |
| rd_valid_o | output | 1 | Read result qualifier |
| ctx_ready_o | output | 1 | Saved context (final tag) ready |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a context write meets the end-of-processing capture. The bench provokes this by raising `ctx_wr_i` and `tag_valid_i` on the same edge. It judges the outcome by `ctx_ready_o` staying low and by a following tag-word read returning the IV word. In the second pair, an IV-word read meets a capture. The bench judges that read by its IV result. Afterward it checks that `ctx_ready_o` is set and that a tag-word read returns the newly captured tag, not IV data.

// File: rtl/tagiv_pkg.sv
package tagiv_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_TAG  = 2'd1,
    SRC_IV   = 2'd2
  } rd_src_e;
endpackage

// File: rtl/tagiv_decode.sv
module tagiv_decode #(
  parameter int          ADDR_W   = 12,
  parameter int          WORDS    = 4,
  parameter int unsigned TAG_BASE = 'h570,
  parameter int unsigned IV_BASE  = 'h540,
  parameter int          IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              tag_hit_o,
  output logic              iv_hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [WORDS-1:0] tag_m;
  logic [WORDS-1:0] iv_m;

  for (genvar k = 0; k < WORDS; k++) begin : g_word
    localparam logic [ADDR_W-1:0] TAG_A = ADDR_W'(TAG_BASE + 4 * k);
    localparam logic [ADDR_W-1:0] IV_A  = ADDR_W'(IV_BASE + 4 * k);
    assign tag_m[k] = (addr_i == TAG_A);
    assign iv_m[k]  = (addr_i == IV_A);
  end

  assign tag_hit_o = |tag_m;
  assign iv_hit_o  = |iv_m;

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < WORDS; k++) begin
      if (tag_m[k] || iv_m[k]) idx_o = IDX_W'(k);
    end
  end

  always_comb begin
    a_not_both_r8: assert (!(tag_hit_o && iv_hit_o));
  end
endmodule

// File: rtl/tagiv_store.sv
module tagiv_store #(
  parameter int TAG_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic             tag_mode_i,
  input  logic             tag_valid_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             ctx_wr_i,
  input  logic             iv_rd_i,
  output logic [TAG_W-1:0] tag_q_o,
  output logic             held_o,
  output logic             ready_o
);
  logic capture;
  logic interim;

  assign capture = tag_valid_i && !busy_i && tag_mode_i;
  assign interim = tag_valid_i && busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_q_o <= '0;
      held_o  <= 1'b0;
      ready_o <= 1'b0;
    end else if (ctx_wr_i) begin
      tag_q_o <= '0;
      held_o  <= 1'b0;
      ready_o <= 1'b0;
    end else if (capture) begin
      tag_q_o <= tag_i;
      held_o  <= 1'b1;
      ready_o <= 1'b1;
    end else if (interim) begin
      tag_q_o <= tag_i;
      held_o  <= 1'b0;
    end else if (iv_rd_i) begin
      held_o  <= 1'b0;
    end
  end

  p_capture_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (capture && !ctx_wr_i) |=> (held_o && ready_o));
  p_ctxwr_clears_r5: assert property (@(posedge clk) disable iff (rst)
    ctx_wr_i |=> (!held_o && !ready_o));
  p_ctxwr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (ctx_wr_i && tag_valid_i) |=> !ready_o);
  p_ivread_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (iv_rd_i && !tag_valid_i && !ctx_wr_i) |=> (!held_o && $stable(ready_o)));
  p_capture_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (iv_rd_i && capture && !ctx_wr_i) |=> held_o);
  p_interim_drops_r12: assert property (@(posedge clk) disable iff (rst)
    (interim && !ctx_wr_i) |=> !held_o);
  p_held_ready_r4: assert property (@(posedge clk) disable iff (rst)
    held_o |-> ready_o);
endmodule

// File: rtl/tagiv_rdmux.sv
module tagiv_rdmux
  import tagiv_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  parameter int TAG_W  = DATA_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic              tag_hit_i,
  input  logic              iv_hit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              busy_i,
  input  logic              tag_mode_i,
  input  logic              held_i,
  input  logic              ready_i,
  input  logic [TAG_W-1:0]  tag_q_i,
  input  logic [TAG_W-1:0]  iv_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);
  logic [DATA_W-1:0] tag_w [WORDS];
  logic [DATA_W-1:0] iv_w  [WORDS];
  rd_src_e           src;
  logic [DATA_W-1:0] nxt;

  for (genvar k = 0; k < WORDS; k++) begin : g_split
    assign tag_w[k] = tag_q_i[k*DATA_W +: DATA_W];
    assign iv_w[k]  = iv_i[k*DATA_W +: DATA_W];
  end

  always_comb begin
    src = SRC_NONE;
    if (iv_hit_i) begin
      src = SRC_IV;
    end else if (tag_hit_i) begin
      if (busy_i)                             src = SRC_NONE;
      else if (tag_mode_i && held_i && ready_i) src = SRC_TAG;
      else                                    src = SRC_IV;
    end
  end

  always_comb begin
    case (src)
      SRC_TAG: nxt = tag_w[idx_i];
      SRC_IV:  nxt = iv_w[idx_i];
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      rd_data_o  <= rd_en_i ? nxt : '0;
    end
  end

  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> (!rd_valid_o && rd_data_o == '0));
  p_busy_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && tag_hit_i && busy_i) |=> (rd_data_o == '0));
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !tag_hit_i && !iv_hit_i) |=> (rd_data_o == '0));
endmodule

// File: rtl/tagiv_readback.sv
module tagiv_readback #(
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter int          WORDS    = 4,
  parameter int unsigned TAG_BASE = 'h570,
  parameter int unsigned IV_BASE  = 'h540
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    busy_i,
  input  logic                    tag_mode_i,
  input  logic                    tag_valid_i,
  input  logic [DATA_W*WORDS-1:0] tag_i,
  input  logic [DATA_W*WORDS-1:0] iv_i,
  input  logic                    ctx_wr_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  output logic [DATA_W-1:0]       rd_data_o,
  output logic                    rd_valid_o,
  output logic                    ctx_ready_o
);
  localparam int TAG_W = DATA_W * WORDS;
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic             tag_hit, iv_hit;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag_q;
  logic             held;

  tagiv_decode #(
    .ADDR_W(ADDR_W), .WORDS(WORDS), .TAG_BASE(TAG_BASE),
    .IV_BASE(IV_BASE), .IDX_W(IDX_W)
  ) u_decode (
    .addr_i(rd_addr_i), .tag_hit_o(tag_hit), .iv_hit_o(iv_hit), .idx_o(idx)
  );

  tagiv_store #(.TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst), .busy_i(busy_i), .tag_mode_i(tag_mode_i),
    .tag_valid_i(tag_valid_i), .tag_i(tag_i), .ctx_wr_i(ctx_wr_i),
    .iv_rd_i(rd_en_i && iv_hit), .tag_q_o(tag_q), .held_o(held),
    .ready_o(ctx_ready_o)
  );

  tagiv_rdmux #(
    .DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W), .TAG_W(TAG_W)
  ) u_rdmux (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .tag_hit_i(tag_hit),
    .iv_hit_i(iv_hit), .idx_i(idx), .busy_i(busy_i), .tag_mode_i(tag_mode_i),
    .held_i(held), .ready_i(ctx_ready_o), .tag_q_i(tag_q), .iv_i(iv_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o)
  );
endmodule

// File: tb/tagiv_readback_test.sv
module tagiv_readback_test;
  localparam logic [127:0] TAGV  = 128'hA3A3A3A3_B2B2B2B2_C1C1C1C1_D0D0D0D0;
  localparam logic [127:0] TAGV2 = 128'h0F0F0F0F_1E1E1E1E_2D2D2D2D_3C3C3C3C;
  localparam logic [127:0] IVV   = 128'h44440003_33330002_22220001_11110000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         busy = 1'b0, tag_mode = 1'b1, tag_valid = 1'b0, ctx_wr = 1'b0;
  logic [127:0] tag_in = '0;
  logic [127:0] iv_in = IVV;
  logic         rd_en = 1'b0;
  logic [11:0]  rd_addr = '0;
  logic [31:0]  rd_data;
  logic         rd_valid, ctx_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tagiv_readback uut (
    .clk(clk), .rst(rst), .busy_i(busy), .tag_mode_i(tag_mode),
    .tag_valid_i(tag_valid), .tag_i(tag_in), .iv_i(iv_in), .ctx_wr_i(ctx_wr),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .ctx_ready_o(ctx_ready)
  );

  // exp: 0 = zero, 1 = tag word, 2 = IV word; word index is addr[3:2]
  typedef struct packed {
    logic        cap;
    logic        busy;
    logic        mode;
    logic [11:0] addr;
    logic [1:0]  exp;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{1'b1, 1'b0, 1'b1, 12'h570, 2'd1},  // R1
    '{1'b1, 1'b0, 1'b1, 12'h574, 2'd1},  // R1
    '{1'b1, 1'b0, 1'b1, 12'h578, 2'd1},  // R1
    '{1'b1, 1'b0, 1'b1, 12'h57C, 2'd1},  // R1
    '{1'b1, 1'b1, 1'b1, 12'h574, 2'd0},  // R2
    '{1'b0, 1'b1, 1'b0, 12'h578, 2'd0},  // R2
    '{1'b1, 1'b0, 1'b0, 12'h570, 2'd2},  // R3
    '{1'b0, 1'b0, 1'b0, 12'h57C, 2'd2},  // R3
    '{1'b0, 1'b0, 1'b1, 12'h574, 2'd2},  // R5 no tag held
    '{1'b1, 1'b0, 1'b1, 12'h544, 2'd2},  // R6
    '{1'b1, 1'b1, 1'b1, 12'h54C, 2'd2},  // R6
    '{1'b1, 1'b0, 1'b1, 12'h560, 2'd0},  // R8
    '{1'b1, 1'b0, 1'b1, 12'h571, 2'd0}   // R8
  };

  function automatic logic [31:0] pick(input logic [1:0] code, input logic [11:0] a,
                                       input logic [127:0] t);
    case (code)
      2'd1:    return t[a[3:2]*32 +: 32];
      2'd2:    return IVV[a[3:2]*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic ctx_write();
    ctx_wr = 1'b1; cyc(); ctx_wr = 1'b0;
  endtask

  task automatic capture(input logic [127:0] t);
    busy = 1'b0; tag_mode = 1'b1; tag_in = t; tag_valid = 1'b1;
    cyc(); tag_valid = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, output logic v);
    rd_en = 1'b1; rd_addr = a; cyc();
    d = rd_data; v = rd_valid; rd_en = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    repeat (3) cyc();
    rst = 1'b0;
    // R9: reset state
    check("R9 rd_valid", {31'b0, rd_valid}, 32'h0);
    check("R9 rd_data", rd_data, 32'h0);
    check("R9 ctx_ready", {31'b0, ctx_ready}, 32'h0);

    for (int i = 0; i < 13; i++) begin
      ctx_write();
      if (VECS[i].cap) capture(TAGV);
      busy = VECS[i].busy; tag_mode = VECS[i].mode;
      rd(VECS[i].addr, d, v);
      check($sformatf("R1/R2/R3/R5/R6/R8 vector %0d", i), d,
            pick(VECS[i].exp, VECS[i].addr, TAGV));
      busy = 1'b0; tag_mode = 1'b1;
    end

    // R7: latency and idle data
    ctx_write(); capture(TAGV);
    rd(12'h578, d, v);
    check("R7 valid after request", {31'b0, v}, 32'h1);
    cyc();
    check("R7 valid low when idle", {31'b0, rd_valid}, 32'h0);
    check("R7 data zero when idle", rd_data, 32'h0);

    // R4: capture sets ready; mode-low pulse ignored
    ctx_write();
    check("R4 ready low before capture", {31'b0, ctx_ready}, 32'h0);
    tag_mode = 1'b0; tag_in = TAGV; tag_valid = 1'b1; cyc(); tag_valid = 1'b0;
    check("R4 mode-low pulse ignored", {31'b0, ctx_ready}, 32'h0);
    tag_mode = 1'b1;
    rd(12'h570, d, v);
    check("R4 no tag after mode-low pulse", d, IVV[31:0]);
    capture(TAGV);
    check("R4 ready after capture", {31'b0, ctx_ready}, 32'h1);

    // R5: context write discards tag
    ctx_write();
    check("R5 ready cleared", {31'b0, ctx_ready}, 32'h0);
    rd(12'h57C, d, v);
    check("R5 tag read gives IV", d, IVV[127:96]);

    // R6: IV first gives IV twice; tag-first ordering works
    capture(TAGV);
    rd(12'h548, d, v);
    check("R6 IV read", d, IVV[95:64]);
    rd(12'h578, d, v);
    check("R6 tag after IV gives IV", d, IVV[95:64]);
    check("R6 ready kept", {31'b0, ctx_ready}, 32'h1);
    ctx_write(); capture(TAGV);
    rd(12'h570, d, v);
    check("R6 tag first", d, TAGV[31:0]);
    rd(12'h540, d, v);
    check("R6 IV second", d, IVV[31:0]);

    // R10: context write and capture in the same cycle
    ctx_write();
    tag_in = TAGV; tag_mode = 1'b1; tag_valid = 1'b1; ctx_wr = 1'b1;
    cyc(); tag_valid = 1'b0; ctx_wr = 1'b0;
    check("R10 ready low", {31'b0, ctx_ready}, 32'h0);
    rd(12'h574, d, v);
    check("R10 tag read gives IV", d, IVV[63:32]);

    // R11: IV read and capture in the same cycle
    ctx_write();
    tag_in = TAGV2; tag_valid = 1'b1; rd_en = 1'b1; rd_addr = 12'h54C;
    cyc(); tag_valid = 1'b0; rd_en = 1'b0;
    check("R11 IV result", rd_data, IVV[127:96]);
    check("R11 ready set", {31'b0, ctx_ready}, 32'h1);
    rd(12'h57C, d, v);
    check("R11 tag held", d, TAGV2[127:96]);

    // R12: intermediate load while busy drops held tag
    ctx_write(); capture(TAGV);
    busy = 1'b1; tag_in = TAGV2; tag_valid = 1'b1; cyc(); tag_valid = 1'b0;
    busy = 1'b0;
    rd(12'h570, d, v);
    check("R12 tag read gives IV", d, IVV[31:0]);

    // R9: reset mid-run
    ctx_write(); capture(TAGV);
    rst = 1'b1; cyc(); rst = 1'b0;
    check("R9 ready after reset", {31'b0, ctx_ready}, 32'h0);
    rd(12'h570, d, v);
    check("R9 tag dropped by reset", d, IVV[31:0]);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule